// File: doc/BRIEF.md
# Zero-Trip Hardware Loop Controller

This block sequences loops without per-iteration branch instructions. A setup command names one of several loop counter sets and supplies the address of the setup instruction, the address of the last instruction in the loop body and a trip count. The trip count comes either from a register value, from that value shifted right by one, or from an immediate field. The loop top is the address directly after the setup instruction.

Each cycle, the core presents the address of the instruction it executes. When that address equals the loop-bottom address of an armed set, the controller steps that set's counter. While iterations remain, it redirects fetch back to the loop top. On the last iteration it lets execution fall through.

Two setup variants test the count source before the loop starts. If the test holds, the controller sends fetch straight to the address after the loop bottom, so a zero-trip loop never runs its body. One variant tests for zero. The other tests for zero or negative, with the value read as signed. All outputs are registered, so a redirect appears one clock after the instruction that causes it.

Top module: `loop_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, the redirect output is low and every loop counter reads zero.
- R2: A setup with kind 0 (register) loads the selected counter with the register value, or with the value shifted right by one when the halve flag is set. It raises no redirect.
- R3: A setup with kind 3 (immediate) loads the selected counter with the immediate, zero-extended, and ignores the halve flag.
- R4: A setup with kind 1 (zero test) whose register value is zero clears the selected counter. One cycle later it raises a redirect to the loop-bottom address plus one.
- R5: A setup with kind 2 (signed test) whose register value is zero or has its sign bit set clears the counter and redirects to the loop-bottom address plus one. A positive value loads the count with no redirect.
- R6: The skip test uses the register value before halving. A zero-test setup with value 1 and halve set does not redirect, and it loads a count of 0.
- R7: When the executed address equals the loop bottom of a set whose counter is above 1, that counter decrements. One cycle later a redirect goes to the setup address plus one.
- R8: When the executed address equals the loop bottom of a set whose counter is 1, the counter becomes 0 and no redirect is raised.
- R9: An executed address that matches no armed set's loop bottom, or that matches a set whose counter is 0, changes no counter and raises no redirect.
- R10: The counter sets are independent. Setup selector value i writes only set i, and loop_counts bits [i*DW +: DW] show set i.
- R11: When several armed sets share a loop bottom, only the lowest-numbered one acts on a match.
- R12: A setup and an executed address in the same cycle: the setup is applied and the executed address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | Setup command present this cycle |
| setup_sel | input | SW | Counter set written by the setup |
| setup_kind | input | 2 | 0 register, 1 zero test, 2 signed test, 3 immediate |
| setup_halve | input | 1 | Load the register value shifted right by one |
| setup_reg | input | DW | Register count source |
| setup_imm | input | IW | Immediate count source |
| setup_pc | input | AW | Address of the setup instruction |
| setup_bottom | input | AW | Address of the last loop-body instruction |
| pc_valid | input | 1 | An instruction executes this cycle |
| pc | input | AW | Address of that instruction |
| redir_valid | output | 1 | Registered fetch redirect |
| redir_addr | output | AW | Redirect target |
| loop_counts | output | NSETS*DW | Counter of every set, set i at [i*DW +: DW] |

## Verification
On every cycle, the assertions check the following:
- Both skip variants redirect to the address after the loop bottom.
- A counter never grows without a setup, and it falls by at most one.
- Every decrement to a non-zero value comes with a redirect, and a final decrement does not.
- An idle cycle yields no redirect.

Only the directed scenarios show the values that cannot be seen from the ports alone: the exact loop-top target, the halved and immediate counts, the priority between sets that share a bottom, and the setup taking precedence over an execute in the same cycle.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic [1:0] {
    LK_REG  = 2'd0,
    LK_ZERO = 2'd1,
    LK_LEZ  = 2'd2,
    LK_IMM  = 2'd3
  } loop_kind_e;
endpackage

// File: rtl/loop_setup_decode.sv
module loop_setup_decode
  import loop_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input  loop_kind_e        kind,
  input  logic              halve,
  input  logic [DW-1:0]     regv,
  input  logic [IW-1:0]     imm,
  output logic              skip,
  output logic [DW-1:0]     count
);
  logic [DW-1:0] reg_cnt;

  always_comb begin
    reg_cnt = halve ? (regv >> 1) : regv;
    unique case (kind)
      LK_ZERO: skip = (regv == '0);
      LK_LEZ:  skip = regv[DW-1] || (regv == '0);
      default: skip = 1'b0;
    endcase
    if (skip)
      count = '0;
    else if (kind == LK_IMM)
      count = {{(DW-IW){1'b0}}, imm};
    else
      count = reg_cnt;
  end
endmodule

// File: rtl/loop_slot.sv
module loop_slot #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_cnt,
  input  logic [AW-1:0] load_top,
  input  logic [AW-1:0] load_bot,
  input  logic          step,
  input  logic [AW-1:0] pc,
  output logic [DW-1:0] cnt,
  output logic [AW-1:0] top,
  output logic          hit
);
  logic [AW-1:0] bot;

  assign hit = (cnt != '0) && (pc == bot);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      top <= '0;
      bot <= '0;
    end else if (load) begin
      cnt <= load_cnt;
      top <= load_top;
      bot <= load_bot;
    end else if (step) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/loop_ctl.sv
module loop_ctl
  import loop_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IW    = 12,
  parameter int NSETS = 2,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                setup_valid,
  input  logic [SW-1:0]       setup_sel,
  input  logic [1:0]          setup_kind,
  input  logic                setup_halve,
  input  logic [DW-1:0]       setup_reg,
  input  logic [IW-1:0]       setup_imm,
  input  logic [AW-1:0]       setup_pc,
  input  logic [AW-1:0]       setup_bottom,
  input  logic                pc_valid,
  input  logic [AW-1:0]       pc,
  output logic                redir_valid,
  output logic [AW-1:0]       redir_addr,
  output logic [NSETS*DW-1:0] loop_counts
);
  logic              skip;
  logic [DW-1:0]     new_cnt;
  logic [DW-1:0]     cnt  [NSETS];
  logic [AW-1:0]     top  [NSETS];
  logic [NSETS-1:0]  hit;
  logic [NSETS-1:0]  take;
  logic              found;
  logic [DW-1:0]     sel_cnt;
  logic [AW-1:0]     sel_top;

  loop_setup_decode #(.DW(DW), .IW(IW)) u_dec (
    .kind  (loop_kind_e'(setup_kind)),
    .halve (setup_halve),
    .regv  (setup_reg),
    .imm   (setup_imm),
    .skip  (skip),
    .count (new_cnt)
  );

  for (genvar g = 0; g < NSETS; g++) begin : g_slot
    loop_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .load     (setup_valid && (setup_sel == SW'(g))),
      .load_cnt (new_cnt),
      .load_top (setup_pc + 1'b1),
      .load_bot (setup_bottom),
      .step     (take[g]),
      .pc       (pc),
      .cnt      (cnt[g]),
      .top      (top[g]),
      .hit      (hit[g])
    );
    assign loop_counts[g*DW +: DW] = cnt[g];
  end

  // lowest-numbered matching set wins
  always_comb begin
    take    = '0;
    found   = 1'b0;
    sel_cnt = '0;
    sel_top = '0;
    for (int i = 0; i < NSETS; i++) begin
      if (pc_valid && !setup_valid && hit[i] && !found) begin
        take[i] = 1'b1;
        found   = 1'b1;
        sel_cnt = cnt[i];
        sel_top = top[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
    end else if (setup_valid) begin
      redir_valid <= skip;
      redir_addr  <= setup_bottom + 1'b1;
    end else if (found) begin
      redir_valid <= (sel_cnt > DW'(1));
      redir_addr  <= sel_top;
    end else begin
      redir_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_ctl_chk.sv
module loop_ctl_chk
  import loop_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NSETS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                setup_valid,
  input logic [1:0]          setup_kind,
  input logic [DW-1:0]       setup_reg,
  input logic [AW-1:0]       setup_bottom,
  input logic                pc_valid,
  input logic                redir_valid,
  input logic [AW-1:0]       redir_addr,
  input logic [NSETS*DW-1:0] loop_counts
);
  // R4
  a_r4_zero_skip: assert property (@(posedge clk) disable iff (rst)
    (setup_valid && setup_kind == LK_ZERO && setup_reg == '0)
    |=> (redir_valid && redir_addr == $past(setup_bottom) + 1'b1));

  // R5
  a_r5_lez_skip: assert property (@(posedge clk) disable iff (rst)
    (setup_valid && setup_kind == LK_LEZ && (setup_reg[DW-1] || setup_reg == '0))
    |=> (redir_valid && redir_addr == $past(setup_bottom) + 1'b1));

  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!setup_valid && !pc_valid) |=> !redir_valid);

  for (genvar g = 0; g < NSETS; g++) begin : g_cnt
    // R7
    a_r7_step_one: assert property (@(posedge clk) disable iff (rst)
      !setup_valid |=> (loop_counts[g*DW +: DW] == $past(loop_counts[g*DW +: DW]) ||
                        loop_counts[g*DW +: DW] == $past(loop_counts[g*DW +: DW]) - 1'b1));
    // R7
    a_r7_step_redirects: assert property (@(posedge clk) disable iff (rst)
      (!setup_valid && loop_counts[g*DW +: DW] > DW'(1))
      |=> (loop_counts[g*DW +: DW] == $past(loop_counts[g*DW +: DW]) || redir_valid));
    // R8
    a_r8_last_falls_through: assert property (@(posedge clk) disable iff (rst)
      (!setup_valid && loop_counts[g*DW +: DW] == DW'(1))
      |=> (loop_counts[g*DW +: DW] != '0 || !redir_valid));
  end
endmodule

bind loop_ctl loop_ctl_chk #(.AW(AW), .DW(DW), .NSETS(NSETS)) u_loop_ctl_chk (
  .clk          (clk),
  .rst          (rst),
  .setup_valid  (setup_valid),
  .setup_kind   (setup_kind),
  .setup_reg    (setup_reg),
  .setup_bottom (setup_bottom),
  .pc_valid     (pc_valid),
  .redir_valid  (redir_valid),
  .redir_addr   (redir_addr),
  .loop_counts  (loop_counts)
);

// File: tb/test_loop_ctl.sv
`timescale 1ns/1ps
module test_loop_ctl;
  localparam int AW = 16, DW = 32, IW = 12, NSETS = 2, SW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic setup_valid = 0, setup_halve = 0, pc_valid = 0;
  logic [SW-1:0] setup_sel = '0;
  logic [1:0] setup_kind = '0;
  logic [DW-1:0] setup_reg = '0;
  logic [IW-1:0] setup_imm = '0;
  logic [AW-1:0] setup_pc = '0, setup_bottom = '0, pc = '0;
  logic redir_valid;
  logic [AW-1:0] redir_addr;
  logic [NSETS*DW-1:0] loop_counts;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  loop_ctl #(.AW(AW), .DW(DW), .IW(IW), .NSETS(NSETS)) i_loop_ctl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cnt_of(input int s);
    return loop_counts[s*DW +: DW];
  endfunction

  task automatic do_setup(input int sel, input int kind, input bit halve,
                          input logic [DW-1:0] rv, input logic [IW-1:0] iv,
                          input logic [AW-1:0] spc, input logic [AW-1:0] bot);
    @(negedge clk);
    setup_valid = 1; setup_sel = SW'(sel); setup_kind = 2'(kind);
    setup_halve = halve; setup_reg = rv; setup_imm = iv;
    setup_pc = spc; setup_bottom = bot;
    @(negedge clk);
    setup_valid = 0; pc_valid = 0;
  endtask

  task automatic do_exec(input logic [AW-1:0] a);
    @(negedge clk);
    pc_valid = 1; pc = a;
    @(negedge clk);
    pc_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 redirect", redir_valid, 0);
    chk("R1 count0", cnt_of(0), 0);
    chk("R1 count1", cnt_of(1), 0);
  endtask

  task automatic t_plain();
    do_setup(0, 0, 0, 32'd7, 0, 16'h10, 16'h20);
    chk("R2 count", cnt_of(0), 7);
    chk("R2 no redirect", redir_valid, 0);
    do_setup(0, 0, 1, 32'd9, 0, 16'h10, 16'h20);
    chk("R2 halved count", cnt_of(0), 4);
  endtask

  task automatic t_imm();
    do_setup(1, 3, 1, 32'd100, 12'hABC, 16'h10, 16'h20);
    chk("R3 imm count", cnt_of(1), 32'hABC);
    chk("R3 no redirect", redir_valid, 0);
  endtask

  task automatic t_zero_skip();
    do_setup(0, 1, 0, 32'd0, 0, 16'h40, 16'h55);
    chk("R4 redirect", redir_valid, 1);
    chk("R4 target", redir_addr, 16'h56);
    chk("R4 count", cnt_of(0), 0);
    do_setup(0, 1, 0, 32'd3, 0, 16'h40, 16'h55);
    chk("R4 nonzero no skip", redir_valid, 0);
    chk("R4 nonzero count", cnt_of(0), 3);
  endtask

  task automatic t_lez();
    do_setup(1, 2, 0, 32'hFFFF_FFFF, 0, 16'h60, 16'h70);
    chk("R5 negative redirect", redir_valid, 1);
    chk("R5 negative target", redir_addr, 16'h71);
    chk("R5 count", cnt_of(1), 0);
    do_setup(1, 2, 0, 32'd0, 0, 16'h60, 16'h80);
    chk("R5 zero redirect", redir_valid, 1);
    chk("R5 zero target", redir_addr, 16'h81);
    do_setup(1, 2, 0, 32'd5, 0, 16'h60, 16'h70);
    chk("R5 positive no skip", redir_valid, 0);
    chk("R5 positive count", cnt_of(1), 5);
  endtask

  task automatic t_halve_test();
    do_setup(0, 1, 1, 32'd1, 0, 16'h40, 16'h55);
    chk("R6 no skip", redir_valid, 0);
    chk("R6 count", cnt_of(0), 0);
  endtask

  task automatic t_run();
    do_setup(0, 0, 0, 32'd3, 0, 16'd100, 16'd110);
    do_exec(16'd110);
    chk("R7 redirect", redir_valid, 1);
    chk("R7 target", redir_addr, 16'd101);
    chk("R7 count", cnt_of(0), 2);
    do_exec(16'd105);
    chk("R9 mismatch quiet", redir_valid, 0);
    chk("R9 mismatch count", cnt_of(0), 2);
    do_exec(16'd110);
    chk("R7 second redirect", redir_valid, 1);
    chk("R7 second count", cnt_of(0), 1);
    do_exec(16'd110);
    chk("R8 no redirect", redir_valid, 0);
    chk("R8 count", cnt_of(0), 0);
    do_exec(16'd110);
    chk("R9 disarmed quiet", redir_valid, 0);
    chk("R9 disarmed count", cnt_of(0), 0);
  endtask

  task automatic t_sets();
    do_setup(1, 0, 0, 32'd5, 0, 16'd190, 16'd200);
    chk("R10 set1 loaded", cnt_of(1), 5);
    chk("R10 set0 untouched", cnt_of(0), 0);
    do_setup(0, 0, 0, 32'd2, 0, 16'd195, 16'd200);
    chk("R10 set1 kept", cnt_of(1), 5);
    do_exec(16'd200);
    chk("R11 set0 target", redir_addr, 16'd196);
    chk("R11 set0 count", cnt_of(0), 1);
    chk("R11 set1 held", cnt_of(1), 5);
    do_exec(16'd200);
    chk("R11 set0 exits", redir_valid, 0);
    chk("R11 set1 still held", cnt_of(1), 5);
    do_exec(16'd200);
    chk("R11 set1 redirect", redir_valid, 1);
    chk("R11 set1 target", redir_addr, 16'd191);
    chk("R11 set1 count", cnt_of(1), 4);
  endtask

  task automatic t_precedence();
    @(negedge clk);
    setup_valid = 1; setup_sel = 0; setup_kind = 2'd0; setup_halve = 0;
    setup_reg = 32'd6; setup_pc = 16'd300; setup_bottom = 16'd310;
    pc_valid = 1; pc = 16'd200;
    @(negedge clk);
    setup_valid = 0; pc_valid = 0;
    chk("R12 setup applied", cnt_of(0), 6);
    chk("R12 exec ignored", cnt_of(1), 4);
    chk("R12 no redirect", redir_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_imm();
    t_zero_skip();
    t_lez();
    t_halve_test();
    t_run();
    t_sets();
    t_precedence();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule